// File: doc/BRIEF.md
# Watchdog and Reset Generator

This block drives an active-low system reset, `reset_n`, from three causes: the power-up condition (the block's own reset input), a flag that reports a low supply, and the expiry of a watchdog timer. Every cause is stretched by a release delay. Reset stays low until the cause has been gone for a fixed number of millisecond ticks.

The watchdog counts ticks from a millisecond tick input and is restarted by falling edges on a shared chip-select / kick input. A 2-bit code picks one of three periods or switches the watchdog off. The counter is cleared and held while reset is asserted, so every period is measured from the moment reset is released. Supply comparison, pad drive and oscillator accuracy lie outside the block.

All periods are parameters counted in ticks. The defaults are 1400, 600 and 200 ticks for the three periods and 200 ticks for the release delay.

Top module: `wdrg_top`

## Requirements
- R1: While `rst_n` is low, `reset_n` is low. After `rst_n` rises with `vcc_low` low, `reset_n` stays low through the first RELEASE_TICKS-1 ticks and goes high on the RELEASE_TICKS-th tick.
- R2: With the watchdog released and no kick, code 0 expires on tick P_LONG, code 1 on tick P_MID and code 2 on tick P_SHORT. Ticks are counted from the last restart, and expiry drives `reset_n` low.
- R3: With code 3 the watchdog never expires, however many ticks pass.
- R4: Only a high-to-low transition on `wdi` restarts the watchdog count. Holding `wdi` high or low does not restart it.
- R5: After an expiry, `reset_n` is low from the next clock edge. It goes high on the RELEASE_TICKS-th tick after the expiry.
- R6: While `vcc_low` is high, `reset_n` is low from the next clock edge. It goes high on the RELEASE_TICKS-th tick after `vcc_low` falls.
- R7: A `vcc_low` pulse during the release delay restarts the full delay of RELEASE_TICKS ticks.
- R8: The watchdog count is cleared and held while reset is asserted. It starts from zero when `reset_n` rises.
- R9: A change of `wd_code` restarts the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| vcc_low | input | 1 | High while the supply is below the trip point |
| wdi | input | 1 | Chip-select / watchdog kick line; falling edges restart the watchdog |
| wd_code | input | 2 | Watchdog period select: 0 long, 1 medium, 2 short, 3 off |
| reset_n | output | 1 | System reset, active low |

## Verification
The assertions assume that `tick_ms` is a single-cycle pulse, and that `wdi` and `wd_code` are already synchronous to `clk`. The bench drives every input on the falling clock edge. It spaces tick pulses two cycles apart and never changes `wdi` in the same cycle as a tick, so a kick and an expiry never compete within one edge. Periods are shrunk to a few ticks, so every code, the kick level holds, a code change and the supply glitch can each be swept tick by tick against counts the bench derives from the requirements.

// File: rtl/wdrg_pkg.sv
package wdrg_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'd0,
    WD_MID   = 2'd1,
    WD_SHORT = 2'd2,
    WD_OFF   = 2'd3
  } wd_sel_e;

  // Period in ticks for a code; zero means the watchdog is off.
  function automatic int unsigned wd_limit(input logic [1:0] code,
                                           input int unsigned p_long,
                                           input int unsigned p_mid,
                                           input int unsigned p_short);
    case (code)
      WD_LONG:  return p_long;
      WD_MID:   return p_mid;
      WD_SHORT: return p_short;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdrg_kick.sv
module wdrg_kick (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  output logic kick
);
  logic wdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdi_q <= 1'b0;
    else        wdi_q <= wdi;
  end

  assign kick = wdi_q & ~wdi;

  // R4: a kick needs the line high one cycle earlier and low now
  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> ($past(wdi) && !wdi));
endmodule

// File: rtl/wdrg_timer.sv
module wdrg_timer
  import wdrg_pkg::*;
#(
  parameter int unsigned P_LONG  = 1400,
  parameter int unsigned P_MID   = 600,
  parameter int unsigned P_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       kick,
  input  logic [1:0] code,
  output logic       expire
);
  localparam int unsigned PMAX = max3(P_LONG, P_MID, P_SHORT);
  localparam int unsigned CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    code_q;
  logic          code_chg;
  logic          restart;
  logic          enabled;
  logic [CW-1:0] last;

  assign code_chg = (code != code_q);
  assign restart  = kick | code_chg;
  assign enabled  = (wd_limit(code, P_LONG, P_MID, P_SHORT) != 0);
  assign last     = CW'(wd_limit(code, P_LONG, P_MID, P_SHORT) - 1);
  assign expire   = tick & ~hold & ~restart & enabled & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      code_q <= WD_LONG;
    end else begin
      code_q <= code;
      if (hold || restart || !enabled || expire) cnt <= '0;
      else if (tick)                             cnt <= cnt + 1'b1;
    end
  end

  a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !tick) |=> (cnt == '0));
  a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (code == WD_OFF) |-> !expire);
endmodule

// File: rtl/wdrg_release.sv
module wdrg_release #(
  parameter int unsigned RELEASE_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cause,
  output logic active
);
  localparam int unsigned RW = $clog2(RELEASE_TICKS + 1);

  logic [RW-1:0] rcnt;
  logic          done;

  assign done = active & tick & (rcnt == RW'(RELEASE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      rcnt   <= '0;
    end else if (cause) begin
      active <= 1'b1;
      rcnt   <= '0;
    end else if (done) begin
      active <= 1'b0;
      rcnt   <= '0;
    end else if (active && tick) begin
      rcnt <= rcnt + 1'b1;
    end
  end

  a_r7_cause_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (active && rcnt == '0));
  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(tick));
endmodule

// File: rtl/wdrg_top.sv
module wdrg_top #(
  parameter int unsigned P_LONG        = 1400,
  parameter int unsigned P_MID         = 600,
  parameter int unsigned P_SHORT       = 200,
  parameter int unsigned RELEASE_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       vcc_low,
  input  logic       wdi,
  input  logic [1:0] wd_code,
  output logic       reset_n
);
  logic kick;
  logic expire;
  logic active;
  logic cause;

  assign cause   = vcc_low | expire;
  assign reset_n = ~active;

  wdrg_kick u_kick (
    .clk   (clk),
    .rst_n (rst_n),
    .wdi   (wdi),
    .kick  (kick)
  );

  wdrg_timer #(
    .P_LONG  (P_LONG),
    .P_MID   (P_MID),
    .P_SHORT (P_SHORT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .hold   (active),
    .kick   (kick),
    .code   (wd_code),
    .expire (expire)
  );

  wdrg_release #(
    .RELEASE_TICKS (RELEASE_TICKS)
  ) u_release (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .cause  (cause),
    .active (active)
  );

  a_r5_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !reset_n);
  a_r6_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |=> !reset_n);
endmodule

// File: tb/wdrg_top_test.sv
module wdrg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 14;
  localparam int PM = 6;
  localparam int PS = 3;
  localparam int RL = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic       vcc_low;
  logic       wdi;
  logic [1:0] wd_code;
  logic       reset_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdrg_top #(.P_LONG(PL), .P_MID(PM), .P_SHORT(PS), .RELEASE_TICKS(RL)) uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vcc_low(vcc_low),
    .wdi(wdi), .wd_code(wd_code), .reset_n(reset_n)
  );

  function automatic int period(input logic [1:0] c);
    return (c == 2'd0) ? PL : (c == 2'd1) ? PM : (c == 2'd2) ? PS : 0;
  endfunction

  task automatic check(input string req, input logic exp);
    n_cmp++;
    if (reset_n !== exp) begin
      n_bad++;
      $display("FAIL %s: reset_n=%b expected %b at %0t", req, reset_n, exp, $time);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic kick1();
    @(negedge clk) wdi = 1'b1;
    @(negedge clk) wdi = 1'b0;
    @(negedge clk);
  endtask

  // Release delay: low through RL-1 ticks, high on tick RL.
  task automatic release_seq(input string req);
    for (int i = 1; i < RL; i++) begin
      tick1();
      check(req, 1'b0);
    end
    tick1();
    check(req, 1'b1);
  endtask

  // Watchdog runs p-1 ticks with reset high, expires on tick p.
  task automatic expire_seq(input string req, input int p);
    for (int i = 1; i < p; i++) begin
      tick1();
      check(req, 1'b1);
    end
    tick1();
    check(req, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, reset_n=%b expected progress", reset_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; vcc_low = 1'b0; wdi = 1'b0; wd_code = 2'd3;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    tick1();
    check("R1 ticks ignored in reset", 1'b0);
    @(negedge clk) rst_n = 1'b1;
    release_seq("R1 power-up");

    // R3: code 3 never expires
    for (int i = 0; i < 3 * PL; i++) begin
      tick1();
      check("R3 off", 1'b1);
    end

    // R2/R5: every enabled code, then the stretched reset
    for (int c = 0; c < 3; c++) begin
      @(negedge clk) wd_code = 2'(c);
      expire_seq("R2 period", period(2'(c)));
      release_seq("R5 stretch");
    end

    // R8: no code change, next expiry counted from release
    expire_seq("R8 count from release", PS);
    release_seq("R5 stretch");

    // R4: falling edge restarts, held levels do not
    @(negedge clk) wd_code = 2'd1;
    @(negedge clk);
    for (int i = 1; i < PM; i++) begin tick1(); check("R4 pre-kick", 1'b1); end
    kick1();
    for (int i = 1; i < PM; i++) begin tick1(); check("R4 after kick", 1'b1); end
    kick1();
    @(negedge clk) wdi = 1'b1;
    expire_seq("R4 held high", PM);
    @(negedge clk) wdi = 1'b0;
    release_seq("R5 stretch");
    expire_seq("R4 held low", PM);
    release_seq("R5 stretch");

    // R9: code change restarts the count
    @(negedge clk) wd_code = 2'd0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin tick1(); check("R9 long run", 1'b1); end
    @(negedge clk) wd_code = 2'd1;
    @(negedge clk);
    expire_seq("R9 after change", PM);
    release_seq("R5 stretch");

    // R6: supply low
    @(negedge clk) wd_code = 2'd3;
    @(negedge clk) vcc_low = 1'b1;
    @(negedge clk);
    check("R6 low asserts", 1'b0);
    for (int i = 0; i < 2 * RL; i++) begin tick1(); check("R6 held", 1'b0); end
    @(negedge clk) vcc_low = 1'b0;
    release_seq("R6 release");

    // R7: glitch in the release delay restarts it
    @(negedge clk) vcc_low = 1'b1;
    @(negedge clk) vcc_low = 1'b0;
    for (int i = 0; i < RL - 2; i++) begin tick1(); check("R7 partial", 1'b0); end
    @(negedge clk) vcc_low = 1'b1;
    @(negedge clk) vcc_low = 1'b0;
    release_seq("R7 full delay");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule